// File: doc/BRIEF.md
# Beacon Timer Set with Window Check

This block keeps four periodic timers that schedule beacon activity for a wireless station: the beacon target time, an early alert that starts beacon DMA, an early alert for software and the end of the announcement window that follows each beacon. The beacon target and window-end timers count whole time units (TU, 1024 us). The two alert timers count eighths of a TU. The block takes the free-running microsecond time stamp counter (TSF) as an input. It compares each armed timer with the matching slice of that counter. When a timer matches exactly, the timer advances by one beacon interval and raises a one-cycle event.

A one-cycle init strobe loads all four timers from a next-beacon time, an operating mode and two alert lead offsets. The same strobe latches the beacon interval and the DMA lead. A pending beacon-miss flag is set by an input pulse, and init clears it.

The time stamp can jump forward, for example when the station adopts a peer's clock. A timer that the counter jumps past does not advance again until the counter wraps back to it, so the spacing between timers can drift. A window checker watches two spacings: window end to beacon target, and DMA alert to beacon target. It accepts the four legal wrap and update orderings and reports a registered pass flag.

Top module: `beacon_timer_set`

## Requirements
- R1: An armed timer advances only in a cycle where its time slice equals its stored value. TU timers use TSF bits [25:10] and advance by the latched interval, modulo 2^16. A timer the TSF has jumped past stays unchanged until the slice wraps back to it.
- R2: The DMA alert and software alert timers are 19 bits wide in 1/8-TU units and compare against TSF bits [25:7]. Each advances by interval<<3. In ad-hoc (mode 1), AP (mode 2) and mesh (mode 3) modes, init loads them with ((next − lead) mod 2^16)<<3 and arms them. In station mode (mode 0), init loads them with 0 and leaves them disarmed.
- R3: Init loads the window-end timer with next+1 (mod 2^16) and arms it.
- R4: Init loads the beacon target timer with 0 in AP and mesh modes and with next in station and ad-hoc modes, and arms it.
- R5: evt_o bit 0 is the beacon target, bit 1 the DMA alert, bit 2 the software alert and bit 3 the window end. Each bit pulses in the cycle after its timer matched.
- R6: win_ok_o is 1 when both spacings pass. The first spacing is from the beacon target to the window end, with window 1. The second is from the DMA alert (>>3) to the beacon target, with window equal to the DMA lead. A spacing from A to B with window w and interval I passes when any of these holds: B−A=w; A−B=I−w; (A+2^16)−B=I−w; (B+2^16)−A=w. The flag reflects the timer state of the previous cycle.
- R7: A beacon-miss pulse sets bmiss_pend_o. Init clears it, and init wins when both arrive in the same cycle.
- R8: After reset all timers read 0 and are disarmed, no events fire, and win_ok_o and bmiss_pend_o are 0.
- R9: Init in a cycle where a timer also matches loads the new value, with no increment and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tsf_i | input | 32 | Time stamp counter in microseconds |
| init_i | input | 1 | Load strobe for timers and configuration |
| mode_i | input | 2 | 0 station, 1 ad-hoc, 2 AP, 3 mesh |
| next_tbtt_i | input | 16 | Next beacon time in TU |
| interval_i | input | 16 | Beacon interval in TU |
| dma_lead_i | input | 16 | DMA alert lead in TU |
| sw_lead_i | input | 16 | Software alert lead in TU |
| bmiss_i | input | 1 | Beacon-miss event pulse |
| tbtt_o | output | 16 | Beacon target timer (TU) |
| dma_o | output | 19 | DMA alert timer (1/8 TU) |
| swba_o | output | 19 | Software alert timer (1/8 TU) |
| atim_o | output | 16 | Window-end timer (TU) |
| evt_o | output | 4 | Per-timer match events |
| win_ok_o | output | 1 | Registered window check result |
| bmiss_pend_o | output | 1 | Pending beacon-miss flag |

## Verification
The properties assume that init_i is a single-cycle strobe and that its configuration inputs are stable in that cycle. They also assume that the TSF may take any value in any cycle, since forward jumps are legal. The stimulus keeps to these assumptions. It advances the TSF in 1/8-TU steps across several beacon periods, jumps it past timers, and runs it through the 16-bit TU wrap so that the lagging timer realigns. It also fires init in the same cycle as a match and as a beacon-miss pulse.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    MODE_STATION = 2'd0,
    MODE_ADHOC   = 2'd1,
    MODE_AP      = 2'd2,
    MODE_MESH    = 2'd3
  } bcn_mode_e;

  localparam int unsigned NUM_TIMERS = 4;
  localparam int unsigned IDX_TBTT = 0;
  localparam int unsigned IDX_DMA  = 1;
  localparam int unsigned IDX_SWBA = 2;
  localparam int unsigned IDX_ATIM = 3;

  function automatic logic is_fine(input int unsigned idx);
    return (idx == IDX_DMA) || (idx == IDX_SWBA);
  endfunction
endpackage

// File: rtl/bts_timer.sv
module bts_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         load_arm_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] now_i,
  output logic [W-1:0] cnt_o,
  output logic         evt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         arm_q, arm_d;
  logic         evt_q, evt_d;
  logic         hit;

  always_comb begin
    hit   = arm_q && (now_i == cnt_q);
    cnt_d = cnt_q;
    arm_d = arm_q;
    evt_d = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
      arm_d = load_arm_i;
    end else if (hit) begin
      cnt_d = cnt_q + step_i;
      evt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
      evt_q <= evt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/bts_win_pair.sv
module bts_win_pair #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] win_i,
  input  logic [W-1:0] ival_i,
  output logic         ok_o
);
  localparam int unsigned X = W + 3;
  localparam logic signed [X-1:0] WRAP = X'(1) <<< W;

  logic signed [X-1:0] sa, sb, sw, si, rest;
  logic c_plain, c_a_upd, c_a_wrap, c_b_wrap;

  always_comb begin
    sa   = $signed({3'b000, a_i});
    sb   = $signed({3'b000, b_i});
    sw   = $signed({3'b000, win_i});
    si   = $signed({3'b000, ival_i});
    rest = si - sw;
    c_plain  = (sb - sa) == sw;
    c_a_upd  = (sa - sb) == rest;
    c_a_wrap = ((sa + WRAP) - sb) == rest;
    c_b_wrap = ((sb + WRAP) - sa) == sw;
    ok_o = c_plain || c_a_upd || c_a_wrap || c_b_wrap;
  end
endmodule

// File: rtl/beacon_timer_set.sv
module beacon_timer_set #(
  parameter int unsigned TSF_W  = 32,
  parameter int unsigned TU_W   = 16,
  parameter int unsigned TU_LSB = 10,
  parameter int unsigned EXT    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TSF_W-1:0]     tsf_i,
  input  logic                 init_i,
  input  logic [1:0]           mode_i,
  input  logic [TU_W-1:0]      next_tbtt_i,
  input  logic [TU_W-1:0]      interval_i,
  input  logic [TU_W-1:0]      dma_lead_i,
  input  logic [TU_W-1:0]      sw_lead_i,
  input  logic                 bmiss_i,
  output logic [TU_W-1:0]      tbtt_o,
  output logic [TU_W+EXT-1:0]  dma_o,
  output logic [TU_W+EXT-1:0]  swba_o,
  output logic [TU_W-1:0]      atim_o,
  output logic [3:0]           evt_o,
  output logic                 win_ok_o,
  output logic                 bmiss_pend_o
);
  import bts_pkg::*;

  localparam int unsigned FINE_W   = TU_W + EXT;
  localparam int unsigned FINE_LSB = TU_LSB - EXT;

  logic [TU_W-1:0]   now_tu;
  logic [FINE_W-1:0] now_fine;
  logic [TU_W-1:0]   ival_q, ival_d, dlead_q, dlead_d;
  logic              pend_q, pend_d, win_q, win_d;
  logic              alerts_on, tbtt_zero;
  logic [FINE_W-1:0] ld_val [NUM_TIMERS];
  logic [FINE_W-1:0] step_v [NUM_TIMERS];
  logic [FINE_W-1:0] now_v  [NUM_TIMERS];
  logic [FINE_W-1:0] cur_v  [NUM_TIMERS];
  logic              arm_v  [NUM_TIMERS];
  logic              ok_atim, ok_dma;

  assign now_tu   = tsf_i[TU_LSB+TU_W-1:TU_LSB];
  assign now_fine = tsf_i[TU_LSB+TU_W-1:FINE_LSB];

  always_comb begin
    alerts_on = (bcn_mode_e'(mode_i) != MODE_STATION);
    tbtt_zero = (bcn_mode_e'(mode_i) == MODE_AP) || (bcn_mode_e'(mode_i) == MODE_MESH);
    ld_val[IDX_TBTT] = tbtt_zero ? '0 : FINE_W'(next_tbtt_i);
    ld_val[IDX_DMA]  = alerts_on ? {TU_W'(next_tbtt_i - dma_lead_i), EXT'(0)} : '0;
    ld_val[IDX_SWBA] = alerts_on ? {TU_W'(next_tbtt_i - sw_lead_i), EXT'(0)} : '0;
    ld_val[IDX_ATIM] = FINE_W'(TU_W'(next_tbtt_i + 1'b1));
    arm_v[IDX_TBTT]  = 1'b1;
    arm_v[IDX_DMA]   = alerts_on;
    arm_v[IDX_SWBA]  = alerts_on;
    arm_v[IDX_ATIM]  = 1'b1;
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    localparam int unsigned W = is_fine(i) ? FINE_W : TU_W;
    logic [W-1:0] cnt_w;
    if (is_fine(i)) begin : g_fine
      assign now_v[i]  = now_fine;
      assign step_v[i] = {ival_q, EXT'(0)};
    end else begin : g_tu
      assign now_v[i]  = FINE_W'(now_tu);
      assign step_v[i] = FINE_W'(ival_q);
    end
    bts_timer #(.W(W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (init_i),
      .load_arm_i (arm_v[i]),
      .load_val_i (ld_val[i][W-1:0]),
      .step_i     (step_v[i][W-1:0]),
      .now_i      (now_v[i][W-1:0]),
      .cnt_o      (cnt_w),
      .evt_o      (evt_o[i])
    );
    assign cur_v[i] = FINE_W'(cnt_w);
  end

  assign tbtt_o = cur_v[IDX_TBTT][TU_W-1:0];
  assign dma_o  = cur_v[IDX_DMA];
  assign swba_o = cur_v[IDX_SWBA];
  assign atim_o = cur_v[IDX_ATIM][TU_W-1:0];

  bts_win_pair #(.W(TU_W)) u_win_atim (
    .a_i    (tbtt_o),
    .b_i    (atim_o),
    .win_i  (TU_W'(1)),
    .ival_i (ival_q),
    .ok_o   (ok_atim)
  );

  bts_win_pair #(.W(TU_W)) u_win_dma (
    .a_i    (dma_o[FINE_W-1:EXT]),
    .b_i    (tbtt_o),
    .win_i  (dlead_q),
    .ival_i (ival_q),
    .ok_o   (ok_dma)
  );

  always_comb begin
    ival_d  = init_i ? interval_i : ival_q;
    dlead_d = init_i ? dma_lead_i : dlead_q;
    pend_d  = init_i ? 1'b0 : (pend_q | bmiss_i);
    win_d   = ok_atim && ok_dma;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q  <= '0;
      dlead_q <= '0;
      pend_q  <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      ival_q  <= ival_d;
      dlead_q <= dlead_d;
      pend_q  <= pend_d;
      win_q   <= win_d;
    end
  end

  assign win_ok_o     = win_q;
  assign bmiss_pend_o = pend_q;
endmodule

// File: rtl/beacon_timer_set_chk.sv
module beacon_timer_set_chk #(
  parameter int unsigned TSF_W  = 32,
  parameter int unsigned TU_W   = 16,
  parameter int unsigned TU_LSB = 10,
  parameter int unsigned EXT    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [TSF_W-1:0]    tsf_i,
  input logic                init_i,
  input logic [1:0]          mode_i,
  input logic [TU_W-1:0]     next_tbtt_i,
  input logic [TU_W-1:0]     dma_lead_i,
  input logic [TU_W-1:0]     tbtt_o,
  input logic [TU_W+EXT-1:0] dma_o,
  input logic [TU_W-1:0]     atim_o,
  input logic [3:0]          evt_o,
  input logic                bmiss_pend_o
);
  assert_tbtt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(init_i) && !evt_o[0]) |-> $stable(tbtt_o));

  assert_atim_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o[3] && !$past(init_i)) |-> ($past(tsf_i[TU_LSB+TU_W-1:TU_LSB]) == $past(atim_o)));

  assert_dma_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && mode_i != 2'd0) |=>
      (dma_o == {TU_W'($past(next_tbtt_i) - $past(dma_lead_i)), EXT'(0)}));

  assert_atim_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (atim_o == TU_W'($past(next_tbtt_i) + 1'b1)));

  assert_tbtt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && mode_i[1]) |=> (tbtt_o == '0));

  assert_init_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (evt_o == 4'b0000));

  assert_bmiss_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !bmiss_pend_o);
endmodule

bind beacon_timer_set beacon_timer_set_chk #(
  .TSF_W(TSF_W), .TU_W(TU_W), .TU_LSB(TU_LSB), .EXT(EXT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tsf_i        (tsf_i),
  .init_i       (init_i),
  .mode_i       (mode_i),
  .next_tbtt_i  (next_tbtt_i),
  .dma_lead_i   (dma_lead_i),
  .tbtt_o       (tbtt_o),
  .dma_o        (dma_o),
  .atim_o       (atim_o),
  .evt_o        (evt_o),
  .bmiss_pend_o (bmiss_pend_o)
);

// File: tb/tb_beacon_timer_set.sv
`timescale 1ns/1ps
module tb_beacon_timer_set;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tsf = '0;
  logic        init = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] nxt = '0, ival = '0, dlead = '0, slead = '0;
  logic        bmiss = 1'b0;
  logic [15:0] tbtt_o, atim_o;
  logic [18:0] dma_o, swba_o;
  logic [3:0]  evt_o;
  logic        win_ok_o, bmiss_pend_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int  m_tm [4];
  bit  m_arm[4];
  bit  m_ev [4];
  int  m_ival = 0, m_dlead = 0;
  bit  m_pend = 0, m_ok = 0;

  always #2 clk = ~clk;

  beacon_timer_set dut (
    .clk(clk), .rst_n(rst_n), .tsf_i(tsf), .init_i(init), .mode_i(mode),
    .next_tbtt_i(nxt), .interval_i(ival), .dma_lead_i(dlead), .sw_lead_i(slead),
    .bmiss_i(bmiss), .tbtt_o(tbtt_o), .dma_o(dma_o), .swba_o(swba_o),
    .atim_o(atim_o), .evt_o(evt_o), .win_ok_o(win_ok_o), .bmiss_pend_o(bmiss_pend_o)
  );

  function automatic bit spacing_ok(int a, int b, int w, int iv);
    return (b - a == w) || (a - b == iv - w) ||
           ((a + 65536) - b == iv - w) || ((b + 65536) - a == w);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: evaluated on the values present at the edge.
  task automatic model_edge();
    int  tu, fine, nv;
    bit  hit[4];
    bit  alerts;
    bit  ok_n;
    tu   = (tsf >> 10) & 16'hFFFF;
    fine = (tsf >> 7) & 19'h7FFFF;
    ok_n = spacing_ok(m_tm[0], m_tm[3], 1, m_ival) &&
           spacing_ok(m_tm[1] >> 3, m_tm[0], m_dlead, m_ival);
    for (int i = 0; i < 4; i++)
      hit[i] = m_arm[i] && (m_tm[i] == ((i == 1 || i == 2) ? fine : tu));
    if (init) begin
      nv = nxt;
      alerts = (mode != 2'd0);
      m_tm[0] = (mode == 2'd2 || mode == 2'd3) ? 0 : nv;
      m_tm[1] = alerts ? (((nv - dlead) & 16'hFFFF) << 3) : 0;
      m_tm[2] = alerts ? (((nv - slead) & 16'hFFFF) << 3) : 0;
      m_tm[3] = (nv + 1) & 16'hFFFF;
      m_arm[0] = 1; m_arm[1] = alerts; m_arm[2] = alerts; m_arm[3] = 1;
      for (int i = 0; i < 4; i++) m_ev[i] = 0;
      m_ival = ival; m_dlead = dlead;
      m_pend = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        m_ev[i] = hit[i];
        if (hit[i])
          m_tm[i] = (i == 1 || i == 2) ? ((m_tm[i] + (m_ival << 3)) & 19'h7FFFF)
                                       : ((m_tm[i] + m_ival) & 16'hFFFF);
      end
      if (bmiss) m_pend = 1;
    end
    m_ok = ok_n;
  endtask

  task automatic compare();
    check("R1/R4 beacon target", tbtt_o, m_tm[0]);
    check("R2 dma alert", dma_o, m_tm[1]);
    check("R2 sw alert", swba_o, m_tm[2]);
    check("R3 window end", atim_o, m_tm[3]);
    check("R5 events", evt_o, {m_ev[3], m_ev[2], m_ev[1], m_ev[0]});
    check("R6 window check", win_ok_o, m_ok);
    check("R7 beacon miss", bmiss_pend_o, m_pend);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic do_init(int md, int n, int iv, int dl, int sl);
    mode = 2'(md); nxt = 16'(n); ival = 16'(iv); dlead = 16'(dl); slead = 16'(sl);
    init = 1'b1;
    cyc();
    init = 1'b0;
  endtask

  // Walk the TSF in 1/8-TU steps starting at fine-time f0.
  task automatic run(int f0, int n);
    for (int k = 0; k < n; k++) begin
      tsf = 32'(((f0 + k) & 19'h7FFFF) << 7);
      cyc();
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_tm[i] = 0; m_arm[i] = 0; m_ev[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8 reset tbtt", tbtt_o, 0);
    check("R8 reset dma", dma_o, 0);
    check("R8 reset events", evt_o, 0);
    check("R8 reset window", win_ok_o, 0);
    check("R8 reset pend", bmiss_pend_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(0, 20);

    // Ad-hoc: regular periods, all four timers advance (R1, R2, R5, R6)
    do_init(1, 200, 100, 2, 10);
    run(190 * 8, 8 * 250);

    // R7: miss pulse, then init in AP mode on a cycle with a pending pulse
    bmiss = 1'b1; cyc(); bmiss = 1'b0;
    run(440 * 8, 5);
    bmiss = 1'b1;
    do_init(2, 500, 50, 3, 6);
    bmiss = 1'b0;
    run(495 * 8, 8 * 130);
    run(0, 16);

    // R9 / R1: jump past the DMA alert, then wrap back around
    do_init(1, 1000, 100, 2, 7);
    run(996 * 8, 8 * 6);
    run(1099 * 8, 8 * 10);
    run(65530 * 8, 8 * 1115);

    // R9: init in the same cycle the beacon target matches; station mode (R2)
    do_init(0, 50, 40, 2, 4);
    tsf = 32'(50 << 10);
    do_init(0, 60, 40, 2, 4);
    run(55 * 8, 8 * 100);
    bmiss = 1'b1; cyc(); bmiss = 1'b0;
    run(200 * 8, 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule